// File: doc/BRIEF.md
# Shared Multi-Sender Message Queue

This block is a 32-bit message queue that several sending processors share to pass words to a single receiving processor. Each sender has its own push port. A sender places its 6-bit processor ID in the low bits of every word. The upper bits carry the payload, normally a 64-byte-aligned pointer into shared memory. The queue decides whether a push fits and stores it in the same cycle. A push that does not fit is dropped and does not stall the sender. Instead, the drop is recorded in a sticky flag bit selected by the ID inside the dropped word. Each sender reads that flag after pushing to learn whether its message got in, and then clears it.

The receiver uses a small register port. Reading the data register pops the oldest word. Two flag registers hold the 64 per-ID drop bits and are cleared by writing ones. A status register reports the fill level together with empty and full bits. A level interrupt stays high for as long as the queue holds at least one word.

Top module: `ipc_mbox_fifo`

## Requirements
- R1: An accepted push is stored, and pops return accepted words in arrival order as the full 32-bit word, ID bits [5:0] included.
- R2: The queue holds DEPTH (128) words. A push while full is discarded, and flag bit N is set, where N is bits [5:0] of that word. Flag register 0 (address 1) holds IDs 0 to 31 at bits 0 to 31. Flag register 1 (address 2) holds IDs 32 to 63 at bits 0 to 31.
- R3: When several senders push in one cycle, only the lowest-numbered port can be accepted. Every other push in that cycle is discarded and sets its sender's flag bit.
- R4: Fullness is judged before any pop in the same cycle, so a push that meets a full queue is rejected even when a pop happens in that cycle.
- R5: Writing to a flag register clears each bit written as 1 and leaves each bit written as 0 unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R6: The interrupt output is high exactly while the queue holds one or more words.
- R7: A read of the data register (address 0) while the queue is empty returns zero and leaves the level unchanged.
- R8: The status register (address 3) returns the level in bits [15:0], empty in bit 16 and full in bit 17.
- R9: After reset the queue is empty, all flags are zero, and both the interrupt and the read data are zero.
- R10: Read data for a request appears on the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | NUM_WR | Push request, one bit per sender |
| wr_data | input | NUM_WR*32 | Pushed words, sender i at bits [32i+31:32i] |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 data, 1 flags IDs 0-31, 2 flags IDs 32-63, 3 status |
| reg_wdata | input | 32 | Write data (ones clear flag bits) |
| reg_rdata | output | 32 | Registered read data |
| irq_not_empty | output | 1 | High while the queue holds data |

## Verification
A behavioural queue model is stepped alongside the design and compared on every cycle. Single-sender pushes followed by pops show ordering and that the ID bits survive the round trip. Pushes from three senders in the same cycle separate the winning port from the rejected ones, and show that each rejection lands in the flag register selected by the word's own ID. The queue is filled to the limit and then pushed and popped in the same cycle, which tells a full check made before the pop from one made after it. Flag writes of zeros, of ones, and of ones that collide with a new set confirm the clear-on-one behaviour and that a set takes precedence over a clear.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
    localparam int WORD_W  = 32;
    localparam int ID_W    = 6;
    localparam int NUM_IDS = 1 << ID_W;

    typedef enum logic [1:0] {
        SEL_DATA    = 2'd0,
        SEL_FLAG_LO = 2'd1,
        SEL_FLAG_HI = 2'd2,
        SEL_STATUS  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ipc_mbox_arb.sv
module ipc_mbox_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic taken;

    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipc_mbox_store.sv
module ipc_mbox_store #(
    parameter int DEPTH = 128,
    parameter int W     = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wptr = nxt(st_q.wptr);
        if (pop)  st_d.rptr = nxt(st_q.rptr);
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wptr] <= push_data;
    end

    assign head  = mem[st_q.rptr];
    assign count = st_q.cnt;

    // R2: level never exceeds capacity
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    // R2: the caller never stores into a full queue
    a_r2_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt != CNT_W'(DEPTH)));
    // R7: the caller never pops an empty queue
    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));
endmodule

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo
    import ipc_mbox_pkg::*;
#(
    parameter int NUM_WR = 3,
    parameter int DEPTH  = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_WR-1:0]        wr_valid,
    input  logic [NUM_WR*WORD_W-1:0] wr_data,
    input  logic                     reg_valid,
    input  logic                     reg_write,
    input  logic [1:0]               reg_addr,
    input  logic [WORD_W-1:0]        reg_wdata,
    output logic [WORD_W-1:0]        reg_rdata,
    output logic                     irq_not_empty
);
    typedef struct packed {
        logic [NUM_IDS-1:0] flags;
        logic [WORD_W-1:0]  rdata;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_WR-1:0]  grant, rejected;
    logic [WORD_W-1:0]  push_data, head;
    logic [CNT_W-1:0]   count;
    logic               full, empty, push, pop, rd, wr;
    logic [NUM_IDS-1:0] set_vec, clr_vec;
    logic [NUM_IDS-1:0] set_part [NUM_WR];

    ipc_mbox_arb #(.N(NUM_WR)) u_arb (
        .req   (wr_valid),
        .grant (grant)
    );

    ipc_mbox_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .count     (count)
    );

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign push     = (|wr_valid) && !full;
    assign rejected = full ? wr_valid : (wr_valid & ~grant);
    assign rd       = reg_valid && !reg_write;
    assign wr       = reg_valid && reg_write;
    assign pop      = rd && (reg_addr == SEL_DATA) && !empty;

    for (genvar g = 0; g < NUM_WR; g++) begin : g_rej
        assign set_part[g] = rejected[g]
            ? (NUM_IDS'(1) << wr_data[g*WORD_W +: ID_W]) : '0;
    end

    always_comb begin
        push_data = '0;
        set_vec   = '0;
        for (int i = 0; i < NUM_WR; i++) begin
            if (grant[i]) push_data = wr_data[i*WORD_W +: WORD_W];
            set_vec = set_vec | set_part[i];
        end
    end

    always_comb begin
        clr_vec = '0;
        if (wr && reg_addr == SEL_FLAG_LO) clr_vec[31:0]  = reg_wdata;
        if (wr && reg_addr == SEL_FLAG_HI) clr_vec[63:32] = reg_wdata;
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_vec) | set_vec;
        if (rd) begin
            case (reg_sel_e'(reg_addr))
                SEL_DATA:    st_d.rdata = empty ? '0 : head;
                SEL_FLAG_LO: st_d.rdata = st_q.flags[31:0];
                SEL_FLAG_HI: st_d.rdata = st_q.flags[63:32];
                SEL_STATUS:  st_d.rdata = {14'd0, full, empty, 16'(count)};
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata     = st_q.rdata;
    assign irq_not_empty = !empty;

    // R2: a push from port 0 meeting a full queue leaves its ID flag set
    a_r2_full_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid[0]) |=> st_q.flags[$past(wr_data[ID_W-1:0])]);
    // R4: full with a pop drops exactly one entry, no push sneaks in
    a_r4_full_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pop) |=> (count == CNT_W'(DEPTH - 1)));
    // R6: the interrupt only falls because of a pop
    a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_not_empty) |-> $past(pop));
    // R7: a data read while empty returns zero
    a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && reg_addr == SEL_DATA && empty) |=> (reg_rdata == '0));
    // R3: at most one push is accepted per cycle
    a_r3_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_valid & ~rejected) <= 1);
endmodule

// File: tb/ipc_mbox_fifo_bench.sv
module ipc_mbox_fifo_bench;
    localparam int NW = 3;
    localparam int DP = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NW-1:0]    wv = '0;
    logic [NW*32-1:0] wd = '0;
    logic        rv = 1'b0, rw = 1'b0;
    logic [1:0]  ra = '0;
    logic [31:0] rwd = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    ipc_mbox_fifo u_ipc_mbox_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_data(wd),
        .reg_valid(rv), .reg_write(rw), .reg_addr(ra), .reg_wdata(rwd),
        .reg_rdata(rdata), .irq_not_empty(irq)
    );

    // behavioural reference
    logic [31:0] mq [$];
    logic [63:0] mflags = '0;
    logic [31:0] mrdata = '0;
    logic        mfull, maccepted;
    logic [63:0] mset, mclr;
    logic [31:0] mpush;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mflags = '0;
            mrdata = '0;
        end else begin
            mfull = (mq.size() == DP);
            if (rv && !rw) begin
                case (ra)
                    2'd0: mrdata = (mq.size() != 0) ? mq[0] : 32'd0;
                    2'd1: mrdata = mflags[31:0];
                    2'd2: mrdata = mflags[63:32];
                    default: mrdata = {14'd0, mfull, mq.size() == 0, 16'(mq.size())};
                endcase
            end
            mset = '0;
            maccepted = 1'b0;
            mpush = '0;
            for (int i = 0; i < NW; i++) begin
                if (wv[i]) begin
                    if (!mfull && !maccepted) begin
                        maccepted = 1'b1;
                        mpush = wd[i*32 +: 32];
                    end else begin
                        mset[wd[i*32 +: 6]] = 1'b1;
                    end
                end
            end
            mclr = '0;
            if (rv && rw && ra == 2'd1) mclr[31:0]  = rwd;
            if (rv && rw && ra == 2'd2) mclr[63:32] = rwd;
            mflags = (mflags & ~mclr) | mset;
            if (rv && !rw && ra == 2'd0 && mq.size() != 0) void'(mq.pop_front());
            if (maccepted) mq.push_back(mpush);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 R10 rdata vs model", rdata, mrdata);
            check("R6 irq vs model", {31'd0, irq}, {31'd0, mq.size() != 0});
        end
    end

    task automatic idle();
        wv = '0; rv = 1'b0; rw = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input int port, input logic [31:0] w);
        wv = '0;
        wv[port] = 1'b1;
        wd[port*32 +: 32] = w;
        @(negedge clk);
        wv = '0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] v);
        rv = 1'b1; rw = 1'b0; ra = a;
        @(negedge clk);
        rv = 1'b0;
        v = rdata;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] v);
        rv = 1'b1; rw = 1'b1; ra = a; rwd = v;
        @(negedge clk);
        rv = 1'b0; rw = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check("R9 reset irq", {31'd0, irq}, 32'd0);
        check("R9 reset rdata", rdata, 32'd0);
        rst_n = 1'b1;
        idle();
        rreg(2'd3, v);
        check("R9 R8 status after reset", v, 32'h0001_0000);

        // R1 ordering and ID bits retained
        push(0, 32'hABCD_0040 | 32'd7);
        push(0, 32'h1234_5680 | 32'd2);
        check("R6 irq set", {31'd0, irq}, 32'd1);
        rreg(2'd0, v);
        check("R1 first pop", v, 32'hABCD_0047);
        rreg(2'd0, v);
        check("R1 second pop", v, 32'h1234_5682);
        idle();
        check("R6 irq cleared", {31'd0, irq}, 32'd0);

        // R3 same-cycle contention
        wv = 3'b111;
        wd = {32'h0000_0C00 | 32'd40, 32'h0000_0B00 | 32'd5, 32'h0000_0A00 | 32'd1};
        @(negedge clk);
        wv = '0;
        rreg(2'd1, v);
        check("R3 loser flag low", v, 32'h0000_0020);
        rreg(2'd2, v);
        check("R3 loser flag high", v, 32'h0000_0100);
        rreg(2'd0, v);
        check("R3 winner stored", v, 32'h0000_0A01);

        // R5 write-one-to-clear
        wreg(2'd1, 32'h0);
        rreg(2'd1, v);
        check("R5 zero write keeps", v, 32'h0000_0020);
        wreg(2'd1, 32'h0000_0020);
        rreg(2'd1, v);
        check("R5 one clears", v, 32'h0);
        wv = 3'b011;
        wd[31:0] = 32'h0000_0D03; wd[63:32] = 32'h0000_0E09;
        rv = 1'b1; rw = 1'b1; ra = 2'd1; rwd = 32'h0000_0200;
        @(negedge clk);
        wv = '0; rv = 1'b0; rw = 1'b0;
        rreg(2'd1, v);
        check("R5 set wins over clear", v, 32'h0000_0200);
        wreg(2'd1, 32'hFFFF_FFFF);
        wreg(2'd2, 32'hFFFF_FFFF);

        // R2 fill to capacity (one already in queue)
        for (int i = 1; i < DP; i++) push(1, (i << 6) | 32'd3);
        rreg(2'd3, v);
        check("R2 R8 status full", v, 32'h0002_0080);
        push(2, 32'h0000_5521);
        rreg(2'd2, v);
        check("R2 overflow flag id 33", v, 32'h0000_0002);
        rreg(2'd3, v);
        check("R2 level unchanged", v, 32'h0002_0080);

        // R4 push while full with pop in same cycle
        wv = 3'b001; wd[31:0] = 32'h0000_7704;
        rv = 1'b1; rw = 1'b0; ra = 2'd0;
        @(negedge clk);
        wv = '0; rv = 1'b0;
        check("R4 popped oldest", rdata, 32'h0000_0D03);
        rreg(2'd3, v);
        check("R4 level after pop", v, 32'h0000_007F);
        rreg(2'd1, v);
        check("R4 rejected push flagged", v, 32'h0000_0010);

        // drain, then R7 empty read
        for (int i = 0; i < DP - 1; i++) rreg(2'd0, v);
        check("R1 last drained word", v, (32'd127 << 6) | 32'd3);
        rreg(2'd0, v);
        check("R7 empty read zero", v, 32'h0);
        rreg(2'd3, v);
        check("R7 R8 level stays empty", v, 32'h0001_0000);
        idle();
        idle();
        check("R10 rdata holds", rdata, 32'h0001_0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule